// File: doc/BRIEF.md
# Flat-Table IOVA Page Translator

This block turns 32-bit I/O virtual addresses issued by DMA clients into physical addresses. It uses one flat table in memory, with one 32-bit descriptor for each 4 KiB page. The full 4 GiB space therefore needs a table of exactly 4 MiB. Eight recent translations are kept in a small fully associative TLB. On a miss, the block issues a single memory read for the descriptor, decodes it and either answers with the physical address or reports a translation fault. A faulting access is steered to a protect buffer whose address software sets up.

Software writes two registers through a simple write port. The first holds the table base and the second holds the protect-buffer address. Clients present one request at a time with a valid/ready pair. Each accepted request produces exactly one response pulse.

Top module: `iova_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0. The TLB is empty, so the first request always causes a table walk.
- R2: The table base register is written at offset 0x000. A walk reads the descriptor at base + IOVA[31:12]*4, using 32-bit wrap-around arithmetic. A write to any offset other than 0x000 or 0x214 changes nothing.
- R3: Descriptor bit 1 is the valid flag and bit 3 is the non-secure flag. For a descriptor with bit 1 set, rsp_paddr is {descriptor[31:12], IOVA[11:0]}, rsp_nonsec is descriptor bit 3 and rsp_fault is 0.
- R4: A descriptor with bit 1 clear, including the all-zero descriptor, gives rsp_fault=1, rsp_nonsec=0 and rsp_paddr equal to the protect register. That register is written at offset 0x214 and always has bits [6:0] cleared, so it is 128-byte aligned.
- R5: On a TLB hit, rsp_valid rises in the cycle after the request is accepted, and no memory read is issued.
- R6: Only descriptors with bit 1 set are stored in the TLB. A repeated request to a faulting page walks again.
- R7: The TLB holds 8 entries and replaces them in round-robin order starting from entry 0. After 9 distinct fills, the first page is evicted, and refilling it evicts the second page.
- R8: Only one walk is in flight. req_ready is 0 from the acceptance of a miss until the cycle its response is delivered, and mem_req_valid is a single-cycle pulse.
- R9: Writing the table base register invalidates every TLB entry.
- R10: mem_req_valid is high in the cycle right after a miss is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_iova | input | 32 | I/O virtual address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical or protect-buffer address |
| rsp_fault | output | 1 | Translation fault |
| rsp_nonsec | output | 1 | Page marked non-secure |
| mem_req_valid | output | 1 | Descriptor read request pulse |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor read data valid |
| mem_rsp_data | input | 32 | Descriptor read data |

## Verification
The bench sweeps a run of consecutive pages whose descriptors are computed arithmetically. Each page is one of three kinds:
- all-zero,
- non-zero but with the valid bit clear,
- valid, with the non-secure bit alternating.

Each page is requested twice. The second request separates a cached translation (answered in one cycle with no read) from a fault that must walk again. A page near the top of the space checks the descriptor address arithmetic. Changing the base separates a real flush from a write that is ignored. A run of nine fills followed by targeted re-requests pins down the round-robin victim order.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int CFG_AW     = 12;
  localparam int ALIGN_BITS = 7;
  localparam int DESC_VALID_BIT = 1;
  localparam int DESC_NS_BIT    = 3;
  localparam logic [CFG_AW-1:0] OFS_TBASE = 12'h000;
  localparam logic [CFG_AW-1:0] OFS_PROT  = 12'h214;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} walk_state_t;
endpackage

// File: rtl/xlate_cfg.sv
module xlate_cfg
  import xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [VA_W-1:0]   wdata,
  output logic [VA_W-1:0]   tbase,
  output logic [VA_W-1:0]   prot,
  output logic              flush
);
  assign flush = we && (addr == OFS_TBASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbase <= '0;
      prot  <= '0;
    end else if (we) begin
      if (addr == OFS_TBASE) tbase <= wdata;
      if (addr == OFS_PROT)  prot  <= {wdata[VA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_ns,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_ns
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] ns_q;
  logic [ENTRIES-1:0] match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   victim;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    lk_ns  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_ppn = lk_ppn | ppn_q[i];
        lk_ns  = lk_ns | ns_q[i];
      end
    end
  end
  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld    <= '0;
      victim <= '0;
    end else if (fill_en) begin
      vld[victim] <= 1'b1;
      victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[victim] <= fill_vpn;
      ppn_q[victim] <= fill_ppn;
      ns_q[victim]  <= fill_ns;
    end
  end

  // R7
  single_hit_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(match))
    else $error("more than one TLB entry matches");
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_iova,
  output logic             req_ready,
  input  logic             hit,
  input  logic [VPN_W-1:0] hit_ppn,
  input  logic             hit_ns,
  input  logic [VA_W-1:0]  tbase,
  input  logic [VA_W-1:0]  prot,
  output logic             mem_req_valid,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [VA_W-1:0]  mem_rsp_data,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [VPN_W-1:0] fill_ppn,
  output logic             fill_ns,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             rsp_nonsec
);
  walk_state_t           state;
  logic [VPN_W-1:0]      pend_vpn;
  logic [PAGE_SHIFT-1:0] pend_off;
  logic                  desc_ok;
  logic                  unused_desc;

  assign desc_ok       = mem_rsp_data[DESC_VALID_BIT];
  assign unused_desc   = ^{mem_rsp_data[PAGE_SHIFT-1:DESC_NS_BIT+1], mem_rsp_data[DESC_NS_BIT-1],
                           mem_rsp_data[0]};
  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign fill_en       = (state == ST_WAIT) && mem_rsp_valid && desc_ok;
  assign fill_vpn      = pend_vpn;
  assign fill_ppn      = mem_rsp_data[VA_W-1:PAGE_SHIFT];
  assign fill_ns       = mem_rsp_data[DESC_NS_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_fault    <= 1'b0;
      rsp_nonsec   <= 1'b0;
      pend_vpn     <= '0;
      pend_off     <= '0;
      mem_req_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          if (hit) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= {hit_ppn, req_iova[PAGE_SHIFT-1:0]};
            rsp_fault  <= 1'b0;
            rsp_nonsec <= hit_ns;
          end else begin
            pend_vpn     <= req_iova[VA_W-1:PAGE_SHIFT];
            pend_off     <= req_iova[PAGE_SHIFT-1:0];
            mem_req_addr <= tbase + {{(VA_W-VPN_W-2){1'b0}}, req_iova[VA_W-1:PAGE_SHIFT], 2'b00};
            state        <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          state     <= ST_IDLE;
          if (desc_ok) begin
            rsp_paddr  <= {mem_rsp_data[VA_W-1:PAGE_SHIFT], pend_off};
            rsp_fault  <= 1'b0;
            rsp_nonsec <= mem_rsp_data[DESC_NS_BIT];
          end else begin
            rsp_paddr  <= prot;
            rsp_fault  <= 1'b1;
            rsp_nonsec <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && hit |=> rsp_valid && !rsp_fault && !mem_req_valid)
    else $error("hit did not answer next cycle");
  // R10
  miss_issue_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !hit |=> mem_req_valid && !rsp_valid)
    else $error("miss did not issue a read");
  // R8
  walk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid && !req_ready)
    else $error("read request longer than one cycle");
  // R4
  prot_align_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr[ALIGN_BITS-1:0] == '0 && !rsp_nonsec)
    else $error("fault address not aligned");
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import xlate_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [VA_W-1:0]   cfg_wdata,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_iova,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_nonsec,
  output logic              mem_req_valid,
  output logic [VA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [VA_W-1:0]   mem_rsp_data
);
  logic [VA_W-1:0]  tbase, prot;
  logic             flush, hit, hit_ns, fill_en, fill_ns;
  logic [VPN_W-1:0] hit_ppn, fill_vpn, fill_ppn;

  xlate_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .tbase(tbase), .prot(prot), .flush(flush)
  );

  xlate_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_tlb (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_vpn(req_iova[VA_W-1:PAGE_SHIFT]), .lk_hit(hit), .lk_ppn(hit_ppn), .lk_ns(hit_ns),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_ns(fill_ns)
  );

  xlate_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_iova(req_iova), .req_ready(req_ready),
    .hit(hit), .hit_ppn(hit_ppn), .hit_ns(hit_ns), .tbase(tbase), .prot(prot),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_ns(fill_ns),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec)
  );
endmodule

// File: tb/tb_iova_xlate.sv
module tb_iova_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_iova = '0;
  logic        req_ready, rsp_valid, rsp_fault, rsp_nonsec, mem_req_valid;
  logic [31:0] rsp_paddr, mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int errors = 0;
  int checks = 0;
  int walks = 0;
  int mem_cnt = 0;
  logic [31:0] cur_base = '0;
  logic [31:0] exp_prot = '0;
  logic [31:0] last_addr = '0;
  logic [31:0] pend_addr = '0;

  always #2 clk = ~clk;

  iova_xlate dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_iova(req_iova), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] desc_of(input logic [19:0] vpn);
    if (vpn % 5 == 0)      return 32'h0;
    else if (vpn % 7 == 3) return {vpn ^ 20'h5A5A5, 12'h00D};
    else                   return {vpn ^ 20'h3C3C3, 8'hA0, vpn[0], 1'b0, 1'b1, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model: fixed read latency, descriptor computed from the address
  always @(negedge clk) begin
    if (mem_cnt > 0) begin
      mem_cnt--;
      if (mem_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = desc_of(20'((pend_addr - cur_base) >> 2));
      end
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (mem_req_valid) begin
      walks++;
      last_addr = mem_req_addr;
      pend_addr = mem_req_addr;
      mem_cnt = 2;
    end
  end

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] iova, input bit exp_hit, input string tag);
    logic [31:0] d, ep;
    int w0, lat;
    d  = desc_of(iova[31:12]);
    ep = d[1] ? {d[31:12], iova[11:0]} : exp_prot;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    w0 = walks;
    req_valid = 1'b1; req_iova = iova;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (!exp_hit) begin
      // R10 read issued right after acceptance; R8 stall during the walk
      chk(mem_req_valid === 1'b1, {tag, " R10 read issued"}, 32'(mem_req_valid), 32'd1);
      chk(req_ready === 1'b0, {tag, " R8 stalled"}, 32'(req_ready), 32'd0);
    end
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    if (exp_hit) begin
      chk(lat == 1, {tag, " R5 hit latency"}, 32'(lat), 32'd1);
      chk(walks == w0, {tag, " R5 no read on hit"}, 32'(walks - w0), 32'd0);
    end else begin
      chk(walks == w0 + 1, {tag, " R8 one read per miss"}, 32'(walks - w0), 32'd1);
      chk(last_addr == cur_base + {10'b0, iova[31:12], 2'b00}, {tag, " R2 descriptor address"},
          last_addr, cur_base + {10'b0, iova[31:12], 2'b00});
      chk(req_ready === 1'b1, {tag, " R8 ready after response"}, 32'(req_ready), 32'd1);
    end
    chk(rsp_paddr == ep, {tag, d[1] ? " R3 paddr" : " R4 protect addr"}, rsp_paddr, ep);
    chk(rsp_fault == !d[1], {tag, " R4 fault flag"}, 32'(rsp_fault), 32'(!d[1]));
    chk(rsp_nonsec == (d[1] & d[3]), {tag, " R3 nonsec"}, 32'(rsp_nonsec), 32'(d[1] & d[3]));
    @(negedge clk);
    chk(rsp_valid === 1'b0, {tag, " R8 single response"}, 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R8 act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [19:0] pick [9];
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);

    cur_base = 32'h0040_0000;
    cfg_write(12'h000, cur_base);
    cfg_write(12'h214, 32'h1234_56FF);
    exp_prot = 32'h1234_5680;
    xlate(32'h0000_1ABC, 1'b0, "R1 first request walks");

    // sweep: zero, invalid-nonzero and valid pages, each twice (R3 R4 R6)
    for (int v = 2; v < 42; v++) begin
      logic [31:0] ia;
      ia = {20'(v), 12'(v * 37)};
      xlate(ia, 1'b0, "R3 sweep first");
      xlate(ia ^ 32'h0000_0555, desc_of(20'(v)) != 0 && desc_of(20'(v))[1], "R6 sweep repeat");
    end

    // R2 top of space
    xlate(32'hFFFF_E123, 1'b0, "R2 high page");
    xlate(32'hFFFF_E321, 1'b1, "R2 high page hit");
    // R2 write to an unused offset is ignored: entry kept, base unchanged
    cfg_write(12'h004, 32'hDEAD_BEEF);
    xlate(32'hFFFF_E000, 1'b1, "R2 ignored offset keeps entry");
    // R9 base write flushes, new base used
    cur_base = 32'h0080_1000;
    cfg_write(12'h000, cur_base);
    xlate(32'hFFFF_E000, 1'b0, "R9 flush forces walk");
    xlate(32'h0000_1000, 1'b0, "R9 flush low page");

    // R7 round-robin replacement
    cfg_write(12'h000, cur_base);
    n = 0;
    for (int v = 100; n < 9; v++) begin
      if (desc_of(20'(v))[1]) begin
        pick[n] = 20'(v);
        n++;
      end
    end
    for (int i = 0; i < 9; i++) xlate({pick[i], 12'h010}, 1'b0, "R7 fill");
    xlate({pick[1], 12'h020}, 1'b1, "R7 second page kept");
    xlate({pick[0], 12'h030}, 1'b0, "R7 first page evicted");
    xlate({pick[1], 12'h040}, 1'b0, "R7 refill evicted second");
    xlate({pick[3], 12'h050}, 1'b1, "R7 fourth page kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule